// File: doc/BRIEF.md
# Forwarding and Hazard Control Unit

This block is the decision logic of a five-stage in-order pipeline. The five stages are fetch, decode, execute, memory and writeback. It is purely combinational. Each cycle it looks at the source register indices of the instruction sitting in decode. It compares them against the destination indices of the instructions in execute and memory. From this it picks, for every source operand, where the operand comes from: the register file, the execute-stage result or the memory-stage result.

The same logic watches for a load in execute whose loaded value is needed by the instruction right behind it. Bypassing cannot deliver that value in time, so the unit holds the program counter and the fetch/decode register for one cycle. It also pushes an empty slot into execute. When execute resolves a taken branch, the unit discards the two younger instructions already fetched. A discard wins over a hold raised in the same cycle. The datapath multiplexers, register file and ALU sit outside and simply follow these outputs.

Top module: `hazard_ctl`

## Requirements
- R1: A source operand whose index equals the execute-stage destination is given select 2'b01 (execute result). This applies when the execute write enable is set and the index is nonzero. Operand k's select is bits [2k+1:2k] of `byp_sel`.
- R2: A source operand that matches only the memory-stage destination is given select 2'b10 (memory result). The memory write enable must be set and the index must be nonzero.
- R3: When an operand matches valid producers in both execute and memory, the execute-stage producer wins and the select is 2'b01.
- R4: An operand with index 0 always gets select 2'b00 (register file), even if a producer writes index 0.
- R5: A producer whose write enable is clear never causes a match. It neither forwards nor stalls.
- R6: A load in execute whose nonzero, write-enabled destination matches any decode source raises `hold_fetch` and `ex_bubble` in that cycle.
- R7: No stall is raised in two cases: a load in execute that no decode source uses, and a load whose match is only in the memory stage.
- R8: `ex_taken` raises `flush_young` and `ex_bubble` and forces `hold_fetch` low, even when a load-use condition is present in the same cycle.
- R9: With no dependency and no taken branch, every select is 2'b00 and `hold_fetch`, `ex_bubble` and `flush_young` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src | input | NUM_SRC*REG_ADDR_W | Source register indices of the decode instruction, operand k at [k*REG_ADDR_W +: REG_ADDR_W] |
| ex_dst | input | REG_ADDR_W | Destination index of the execute-stage instruction |
| ex_wr_en | input | 1 | Register-write enable of the execute-stage instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_taken | input | 1 | Branch in execute resolved taken |
| mem_dst | input | REG_ADDR_W | Destination index of the memory-stage instruction |
| mem_wr_en | input | 1 | Register-write enable of the memory-stage instruction |
| byp_sel | output | 2*NUM_SRC | Operand source selects: 00 register file, 01 execute, 10 memory |
| hold_fetch | output | 1 | Hold PC and fetch/decode register |
| ex_bubble | output | 1 | Insert an instruction with all write enables cleared into execute |
| flush_young | output | 1 | Discard the instructions in fetch and decode |

## Verification
The bench uses the default build, with five-bit register indices and two source operands per instruction. Both operand paths and their shared load-use OR are therefore exercised. The random register indices are drawn only from 0 to 3. This makes double matches, matches against index 0 and load-use collisions frequent, and those are the cases where priority and the zero rule decide the result.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'b00,
    BYP_EX  = 2'b01,
    BYP_MEM = 2'b10
  } byp_sel_e;
endpackage

// File: rtl/operand_bypass.sv
module operand_bypass
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic [REG_ADDR_W-1:0] src,
  input  logic [REG_ADDR_W-1:0] ex_dst,
  input  logic                  ex_wr_en,
  input  logic [REG_ADDR_W-1:0] mem_dst,
  input  logic                  mem_wr_en,
  output byp_sel_e              sel,
  output logic                  ex_hit
);
  localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

  logic mem_hit;

  always_comb begin
    ex_hit  = ex_wr_en  && (ex_dst  != ZERO_REG) && (src == ex_dst);
    mem_hit = mem_wr_en && (mem_dst != ZERO_REG) && (src == mem_dst);
    if (ex_hit)       sel = BYP_EX;   // younger producer first
    else if (mem_hit) sel = BYP_MEM;
    else              sel = BYP_RF;
  end
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0] ex_hits,
  input  logic               ex_is_load,
  output logic               load_use
);
  always_comb load_use = ex_is_load && (|ex_hits);
endmodule

// File: rtl/redirect_ctl.sv
module redirect_ctl (
  input  logic load_use,
  input  logic ex_taken,
  output logic hold_fetch,
  output logic ex_bubble,
  output logic flush_young
);
  always_comb begin
    flush_young = ex_taken;
    hold_fetch  = load_use && !ex_taken;
    ex_bubble   = load_use || ex_taken;
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int REG_ADDR_W = 5,
  parameter int NUM_SRC    = 2
) (
  input  logic [NUM_SRC*REG_ADDR_W-1:0] dec_src,
  input  logic [REG_ADDR_W-1:0]         ex_dst,
  input  logic                          ex_wr_en,
  input  logic                          ex_is_load,
  input  logic                          ex_taken,
  input  logic [REG_ADDR_W-1:0]         mem_dst,
  input  logic                          mem_wr_en,
  output logic [2*NUM_SRC-1:0]          byp_sel,
  output logic                          hold_fetch,
  output logic                          ex_bubble,
  output logic                          flush_young
);
  localparam int SEL_W = 2;

  logic [NUM_SRC-1:0] ex_hits;
  logic               load_use;

  for (genvar k = 0; k < NUM_SRC; k++) begin : g_op
    byp_sel_e sel_k;
    operand_bypass #(.REG_ADDR_W(REG_ADDR_W)) u_byp (
      .src       (dec_src[k*REG_ADDR_W +: REG_ADDR_W]),
      .ex_dst    (ex_dst),
      .ex_wr_en  (ex_wr_en),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .sel       (sel_k),
      .ex_hit    (ex_hits[k])
    );
    assign byp_sel[k*SEL_W +: SEL_W] = sel_k;

    always_comb begin
      if (sel_k == BYP_EX)
        AST_EX_SEL_VALID: assert (ex_wr_en && ex_dst != '0) else $error("ex select without producer"); // R5
      if (sel_k == BYP_MEM)
        AST_MEM_SEL_VALID: assert (mem_wr_en && mem_dst != '0) else $error("mem select without producer"); // R2
    end
  end

  load_use_detect #(.NUM_SRC(NUM_SRC)) u_lud (
    .ex_hits    (ex_hits),
    .ex_is_load (ex_is_load),
    .load_use   (load_use)
  );

  redirect_ctl u_rdr (
    .load_use    (load_use),
    .ex_taken    (ex_taken),
    .hold_fetch  (hold_fetch),
    .ex_bubble   (ex_bubble),
    .flush_young (flush_young)
  );

  always_comb begin
    AST_HOLD_FLUSH_EXCL: assert (!(hold_fetch && flush_young)) else $error("hold with flush"); // R8
    if (hold_fetch)
      AST_HOLD_BUBBLE: assert (ex_bubble && ex_is_load) else $error("hold without load bubble"); // R6
    if (flush_young)
      AST_FLUSH_BUBBLE: assert (ex_bubble) else $error("flush without bubble"); // R8
  end
endmodule

// File: tb/tb_hazard_ctl.sv
module tb_hazard_ctl;
  localparam int AW = 5;
  localparam int NS = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [NS*AW-1:0] dec_src;
  logic [AW-1:0]    ex_dst, mem_dst;
  logic             ex_wr_en, ex_is_load, ex_taken, mem_wr_en;
  logic [2*NS-1:0]  byp_sel;
  logic             hold_fetch, ex_bubble, flush_young;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  hazard_ctl #(.REG_ADDR_W(AW), .NUM_SRC(NS)) dut (
    .dec_src(dec_src), .ex_dst(ex_dst), .ex_wr_en(ex_wr_en),
    .ex_is_load(ex_is_load), .ex_taken(ex_taken), .mem_dst(mem_dst),
    .mem_wr_en(mem_wr_en), .byp_sel(byp_sel), .hold_fetch(hold_fetch),
    .ex_bubble(ex_bubble), .flush_young(flush_young)
  );

  function automatic logic [2*NS+2:0] model(int s0, int s1, int ed, bit ew, bit ld,
                                            bit br, int md, bit mw);
    int srcs[2];
    bit stall = 0;
    logic [2*NS-1:0] sel = '0;
    srcs[0] = s0; srcs[1] = s1;
    for (int k = 0; k < 2; k++) begin
      if (ew && ed != 0 && srcs[k] == ed) begin
        sel[2*k +: 2] = 2'b01;
        if (ld) stall = 1;
      end else if (mw && md != 0 && srcs[k] == md) sel[2*k +: 2] = 2'b10;
    end
    return {sel, stall && !br, stall || br, br};
  endfunction

  task automatic apply_check(string tag, int s0, int s1, int ed, bit ew, bit ld,
                             bit br, int md, bit mw);
    logic [2*NS+2:0] exp, act;
    @(negedge clk);
    dec_src = {AW'(s1), AW'(s0)};
    ex_dst = AW'(ed); ex_wr_en = ew; ex_is_load = ld; ex_taken = br;
    mem_dst = AW'(md); mem_wr_en = mw;
    #1;
    exp = model(s0, s1, ed, ew, ld, br, md, mw);
    act = {byp_sel, hold_fetch, ex_bubble, flush_young};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  initial begin
    #(8*200000);
    $display("FAIL watchdog: act=timeout exp=finish");
    n_fail++;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // all-idle state: R9
    apply_check("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0);
    apply_check("R9 no dep", 3, 4, 5, 1, 0, 0, 6, 1);
    apply_check("R1 ex src0", 7, 2, 7, 1, 0, 0, 9, 1);
    apply_check("R1 ex src1", 2, 7, 7, 1, 0, 0, 9, 1);
    apply_check("R2 mem src0", 9, 1, 7, 1, 0, 0, 9, 1);
    apply_check("R2 mem both", 9, 9, 7, 1, 0, 0, 9, 1);
    apply_check("R3 ex over mem", 8, 8, 8, 1, 0, 0, 8, 1);
    apply_check("R4 zero ex", 0, 0, 0, 1, 1, 0, 0, 1);
    apply_check("R5 ex we off", 6, 6, 6, 0, 1, 0, 3, 0);
    apply_check("R5 ex off mem on", 6, 6, 6, 0, 0, 0, 6, 1);
    apply_check("R6 load use", 4, 1, 4, 1, 1, 0, 0, 0);
    apply_check("R6 load use src1", 1, 4, 4, 1, 1, 0, 0, 0);
    apply_check("R7 load no user", 1, 2, 4, 1, 1, 0, 0, 0);
    apply_check("R7 load in mem", 4, 2, 5, 1, 0, 0, 4, 1);
    apply_check("R8 taken", 1, 2, 3, 1, 0, 1, 0, 0);
    apply_check("R8 flush over stall", 4, 4, 4, 1, 1, 1, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int s0 = $urandom_range(0, 3), s1 = $urandom_range(0, 3);
      int ed = $urandom_range(0, 3), md = $urandom_range(0, 3);
      apply_check("R1/R2/R3/R6/R8 random", s0, s1, ed, 1'($urandom), 1'($urandom),
                  1'($urandom_range(0, 7) == 0), md, 1'($urandom));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule